// File: doc/BRIEF.md
# Fractional UART baud generator

This block produces the timing strobes for an asynchronous serial port. A programmable divider word sets the length of a sample period in system clock cycles with quarter-cycle resolution. The block emits a one-cycle sample tick at sixteen times the bit rate, and a bit tick on every sixteenth sample tick for the transmitter.

The divider word is 21 bits wide. Bits 5:0 are ignored. Bits 7:6 form a fraction counted in quarters. Bits 20:8 form the integer part. The sample period is 1 + integer + fraction/4 clocks. The quarter steps are produced by a phase accumulator, so each real period is a whole number of clocks and the average over four periods is exact. A word of zero gives a tick on every clock, which is the fastest rate. The divider is sampled only at period boundaries, so rewriting it never shortens the period in progress. Clearing the enable resets all counters and stops all ticks.

Top module: `baud_frac_gen`

## Requirements
- R1: With fraction bits 7:6 equal to zero, every sample period is exactly int+1 clocks, where int is bits 20:8 of the divider word.
- R2: Bits 5:0 of the divider word have no effect on tick timing.
- R3: With a nonzero fraction f, each period is int+1 or int+2 clocks. The phase accumulator starts at 0 on enable. Period k is long exactly when (acc_k + f) >= 4, and then acc_{k+1} = (acc_k + f) mod 4. Any four consecutive periods therefore hold exactly f long ones.
- R4: A divider word of zero asserts the sample tick on every clock while enabled.
- R5: The largest integer part, 8191, gives periods of 8192 or 8193 clocks.
- R6: A new divider word takes effect only after the next sample tick. The period in progress keeps its old length.
- R7: While the enable is low, no ticks are produced and all counters are held cleared. After enable rises, the first sample tick is visible int+1 clocks later.
- R8: The bit tick is high exactly on every 16th sample tick (sample ticks 16, 32, ... after enable) and is never high without a sample tick.
- R9: After reset both tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low holds counters cleared |
| div_i | input | 21 | Divider word: int [20:8], quarter fraction [7:6], ignored [5:0] |
| sample_tick_o | output | 1 | One-cycle tick at 16x the bit rate |
| bit_tick_o | output | 1 | One-cycle tick on every 16th sample tick |

## Verification
The assertions assume the divider word is changed freely but the enable is driven synchronously. They also assume the counters see a stable configuration between boundaries only because the block latches it itself. No assumption is placed on when software writes the divider. The bench changes the divider and enable only on falling edges. It sweeps every fraction against small integer parts with varying junk in the ignored bits, and predicts each period length from the accumulator arithmetic. Separate runs cover the largest integer part, a rewrite in the middle of a period, and a disable in the middle of a period.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;
  localparam int unsigned DIV_W    = 21;
  localparam int unsigned DROP_LSB = 6;
  localparam int unsigned FRAC_W   = 2;
  localparam int unsigned OVS      = 16;
endpackage

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned FRAC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // disabled: accumulator seen as zero so the first period never carries
  assign sum     = {1'b0, (en_i ? acc_q : '0)} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= sum[FRAC_W-1:0];
  end

  p_carry_needs_frac_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (frac_i != '0));
  p_idle_no_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !carry_o);
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             boundary_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             tick_q;

  assign boundary_o = en_i && (cnt_q == lim_q);
  assign tick_o     = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      lim_q  <= reload_i;
      tick_q <= 1'b0;
    end else if (cnt_q == lim_q) begin
      cnt_q  <= '0;
      lim_q  <= reload_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  p_limit_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !boundary_o) |=> (lim_q == $past(lim_q)));
  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && cnt_q == '0));
  p_tick_restarts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (cnt_q == '0));
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  output logic bit_tick_o
);
  localparam int unsigned SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [SUB_W-1:0] sub_q;
  logic             bit_q;

  assign bit_tick_o = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      bit_q <= 1'b0;
    end else if (!en_i) begin
      sub_q <= '0;
      bit_q <= 1'b0;
    end else if (wrap_i) begin
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      bit_q <= (sub_q == SUB_LAST);
    end else begin
      bit_q <= 1'b0;
    end
  end

  p_bit_spacing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q |=> !bit_q);
  p_sub_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= SUB_LAST);
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_frac_pkg::*;
#(
  parameter int unsigned DIV_WIDTH  = DIV_W,
  parameter int unsigned DROP_BITS  = DROP_LSB,
  parameter int unsigned FRAC_BITS  = FRAC_W,
  parameter int unsigned OVERSAMPLE = OVS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [DIV_WIDTH-1:0] div_i,
  output logic                 sample_tick_o,
  output logic                 bit_tick_o
);
  localparam int unsigned INT_W = DIV_WIDTH - DROP_BITS - FRAC_BITS;
  localparam int unsigned CNT_W = INT_W + 1;

  logic [INT_W-1:0]     int_part;
  logic [FRAC_BITS-1:0] frac_part;
  logic                 unused_lsb;
  logic                 carry, boundary;
  logic [CNT_W-1:0]     reload;

  assign int_part   = div_i[DIV_WIDTH-1 -: INT_W];
  assign frac_part  = div_i[DROP_BITS +: FRAC_BITS];
  assign unused_lsb = ^div_i[DROP_BITS-1:0];
  assign reload     = {1'b0, int_part} + CNT_W'(carry);

  baud_phase_acc #(.FRAC_W(FRAC_BITS)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (!en_i || boundary),
    .frac_i  (frac_part),
    .carry_o (carry)
  );

  baud_period_cnt #(.CNT_W(CNT_W)) u_period (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .reload_i   (reload),
    .boundary_o (boundary),
    .tick_o     (sample_tick_o)
  );

  baud_bit_div #(.OVS(OVERSAMPLE)) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .wrap_i     (boundary),
    .bit_tick_o (bit_tick_o)
  );

  p_bit_on_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);
  p_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sample_tick_o && !bit_tick_o));
endmodule

// File: tb/baud_frac_gen_tb.sv
module baud_frac_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [20:0] div_i = '0;
  logic        sample_tick_o, bit_tick_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk_i = ~clk_i;

  baud_frac_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_i(div_i),
    .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait for the next sample tick; c counts falling edges since enable
  task automatic next_tick(inout int c, input int limit);
    do begin
      @(negedge clk_i);
      c++;
      if (bit_tick_o && !sample_tick_o) chk(1'b0, "R8 bit without sample", 1, 0);
    end while (!sample_tick_o && c < limit);
  endtask

  task automatic run_cfg(input logic [20:0] word, input int nper, input string req);
    int ival, fval, acc, s, c, last, exp_len, limit;
    ival = int'(word[20:8]);
    fval = int'(word[7:6]);
    acc = 0; c = 0; last = 0;
    limit = nper * (ival + 3) + 20;
    en_i = 1'b0;
    div_i = word;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!sample_tick_o && !bit_tick_o, "R7 idle ticks", sample_tick_o, 0);
    end
    en_i = 1'b1;
    for (int k = 0; k < nper; k++) begin
      next_tick(c, limit);
      s = acc + fval;
      exp_len = ival + 1 + ((s >= 4) ? 1 : 0);
      acc = s % 4;
      chk(sample_tick_o && (c - last == exp_len), req, c - last, exp_len);
      chk(bit_tick_o == ((k % 16) == 15), "R8 bit tick", bit_tick_o, (k % 16) == 15);
      last = c;
    end
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk_i);
    chk(!sample_tick_o && !bit_tick_o, "R9 reset outputs", sample_tick_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!sample_tick_o && !bit_tick_o, "R9 after release", sample_tick_o, 0);

    // R1 R2 R3 R4: sweep small integer parts, all fractions, junk in ignored bits
    for (int iv = 0; iv < 6; iv++)
      for (int fv = 0; fv < 4; fv++)
        run_cfg({13'(iv), 2'(fv), 6'((iv * 11 + fv * 7 + 5) & 63)}, 32,
                (iv == 0 && fv == 0) ? "R4 zero word" :
                (fv == 0) ? "R1/R2 integer period" : "R3/R2 fractional period");

    // R5: largest integer part with fraction 3
    run_cfg({13'h1FFF, 2'd3, 6'h2A}, 4, "R5 max divider");

    // R6: rewrite mid-period keeps current length
    en_i = 1'b0; div_i = {13'd3, 8'd0};
    repeat (2) @(negedge clk_i);
    en_i = 1'b1; c = 0;
    next_tick(c, 100);
    chk(c == 4, "R6 first period", c, 4);
    repeat (2) begin @(negedge clk_i); c++; end
    div_i = {13'd10, 8'd0};
    next_tick(c, 100);
    chk(c == 8, "R6 old length kept", c, 8);
    next_tick(c, 100);
    chk(c == 19, "R6 new length applied", c, 19);

    // R7: disable mid-period, restart from scratch
    div_i = {13'd6, 2'd1, 6'd0};
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 5; i++) begin
      en_i = (i == 0) ? 1'b1 : 1'b0;
      @(negedge clk_i);
      if (i > 1) chk(!sample_tick_o, "R7 disabled mid-period", sample_tick_o, 0);
    end
    en_i = 1'b1; c = 0;
    next_tick(c, 100);
    chk(c == 7, "R7 first tick after enable", c, 7);
    en_i = 1'b0;
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule